// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

An on-chip synchronous static memory that takes a fresh read or write command on every clock edge and never needs an idle cycle when the traffic switches between reads and writes. Commands, addresses, byte-lane write enables and chip selects are captured on the rising edge. Read data comes out of a dedicated output register one edge after the command register. Write data trails its command by two edges and is parked in a posted-write register before it reaches the array. Because of this, a write followed by a read, or the reverse, costs no bus cycle.

A 2-bit burst counter lets a single loaded address cover four consecutive beats, in linear or interleaved order. A clock enable freezes every register in the block. An asynchronous output enable and an asynchronous sleep input gate the output drivers.

A read that hits a write still sitting in the posted pipeline returns the newest byte-merged data. Software therefore sees every write commanded before the read.

Top module: `nt_sram`

## Requirements
- R1: While `rst_n` is low and after its release, `dout_en` is 0 and `dout` is all zero until a read has been captured; no write is pending.
- R2: A read command captured at clock edge n is driven on `dout` after edge n+1 (with `clk_en` high at both edges, `oe_n` low and `sleep` low).
- R3: Write data for a write command captured at edge n is sampled from `wdata` at edge n+2. Reads and writes may alternate on consecutive cycles with no idle cycle between them.
- R4: Bit k of `lane_we` selects whether bits [9k+8:9k] of the addressed word are updated by a write; lanes whose bit is 0 keep their old contents.
- R5: A read returns the word as modified by every write commanded before it, including writes whose data is still in the posted pipeline, merged byte by byte with the newest write winning.
- R6: With `adv` high, the counter steps through a burst. The beat address is (seed+k) mod 4 in its two low bits when `burst_lin`=1, and seed XOR k when `burst_lin`=0. The seed is the two low bits of the loaded address and k is the beat count. The upper address bits stay those of the load, and the fifth beat wraps back to the seed.
- R7: An advance cycle repeats the operation type of the load that opened the burst; `wr`, `addr` and the chip selects are ignored on advance cycles.
- R8: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: nothing is written, the output is not driven on the following cycle, and subsequent advances are also deselects.
- R9: With `clk_en` low, no register changes: `dout` holds, `wdata` is not sampled, and a waiting write keeps waiting for the next enabled edge.
- R10: `oe_n` high turns the output off at once (`dout_en`=0, `dout`=0) without a clock edge; lowering it again restores the held read data.
- R11: `sleep` high turns the output off at once. Any command sampled while it is high acts as a deselect and ends the current burst. Writes already in the posted pipeline still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes all registers |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 = write, 0 = read (load cycles only) |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| lane_we | input | LANES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, two edges after its command |
| burst_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drivers enabled |

## Verification
A wrong burst counter or a wrong address register shows up as the wrong word one edge after the affected read command. A broken posted-write stage or a missing forwarding path shows up as stale data on a read issued within two cycles of a write to the same word. A fault in the write pipeline that loses or misplaces a commit shows up on a later read of that word, however far away. A clock-enable stall that lets any stage slip corrupts either the held `dout` immediately or the word written two edges later.

// File: rtl/nt_sram.sv
module nt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr,
  input  logic                    adv,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    burst_lin,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              act, opw;
  logic [LANES-1:0]  be1;

  logic [ADDR_W-1:0] a2, pa;
  logic              w2, pv;
  logic [LANES-1:0]  be2, pbe;
  logic [DATA_W-1:0] pd;

  logic [DATA_W-1:0] rd_q, fwd;
  logic              rd_v;

  logic              sel_ok;
  logic [1:0]        low;
  logic [ADDR_W-1:0] a1;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
  assign low    = burst_lin ? base[1:0] + cnt : base[1:0] ^ cnt;
  assign a1     = {base[ADDR_W-1:2], low};

  always_comb begin
    fwd = mem[a1];
    for (int l = 0; l < LANES; l++) begin
      if (pv && pa == a1 && pbe[l])
        fwd[l*LANE_W +: LANE_W] = pd[l*LANE_W +: LANE_W];
      if (w2 && a2 == a1 && be2[l])
        fwd[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
      act  <= 1'b0;
      opw  <= 1'b0;
      be1  <= '0;
      a2   <= '0;
      w2   <= 1'b0;
      be2  <= '0;
      pa   <= '0;
      pv   <= 1'b0;
      pbe  <= '0;
      pd   <= '0;
      rd_q <= '0;
      rd_v <= 1'b0;
    end else if (clk_en) begin
      if (sleep) begin
        act <= 1'b0;
      end else if (!adv) begin
        base <= addr;
        cnt  <= 2'd0;
        act  <= sel_ok;
        opw  <= wr;
      end else if (act) begin
        cnt <= cnt + 2'd1;
      end
      be1  <= lane_we;
      a2   <= a1;
      w2   <= act && opw;
      be2  <= be1;
      pa   <= a2;
      pv   <= w2;
      pbe  <= be2;
      pd   <= wdata;
      rd_v <= act && !opw;
      if (act && !opw)
        rd_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && pv)
      for (int l = 0; l < LANES; l++)
        if (pbe[l])
          mem[pa][l*LANE_W +: LANE_W] <= pd[l*LANE_W +: LANE_W];
  end

  assign dout_en = rd_v && !oe_n && !sleep;
  assign dout    = dout_en ? rd_q : '0;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rd_q) && $stable(cnt) && $stable(pv) && $stable(w2) && $stable(act));

  // R6
  load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv && !sleep |=> cnt == 2'd0);

  // R6
  adv_steps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && act && !sleep |=> cnt == $past(cnt) + 2'd1);

  // R3
  post_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && w2 |=> pv);

  // R2
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && act && !opw |=> rd_v);

  // R11
  sleep_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && sleep |=> !act);
endmodule

// File: tb/nt_sram_tb_top.sv
`timescale 1ns/1ps
module nt_sram_tb_top;
  localparam int AW = 4;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst_n, clk_en, sel_a_n, sel_b, sel_c_n, wr, adv, burst_lin, oe_n, sleep;
  logic [LN-1:0] lane_we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, dout;
  logic dout_en;

  always #2.5 clk = ~clk;

  nt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr(wr), .adv(adv), .lane_we(lane_we), .addr(addr),
    .wdata(wdata), .burst_lin(burst_lin), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en));

  int vecs = 0;
  int errs = 0;
  logic [DW-1:0] model [16];
  logic [DW-1:0] wp0, wp1, cur_d, shown_d;
  logic cur_v, shown_v;
  logic [AW-1:0] b_base;
  logic [1:0] b_cnt;
  logic b_act, b_wr;

  task automatic look(input string tag);
    logic en_e;
    logic [DW-1:0] d_e;
    en_e = shown_v && !oe_n && !sleep;
    d_e  = en_e ? shown_d : '0;
    vecs++;
    if (dout !== d_e || dout_en !== en_e) begin
      errs++;
      $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", tag, dout, dout_en, d_e, en_e);
    end
  endtask

  task automatic step(input bit ce, input bit [2:0] sel, input bit wr_i, input bit adv_i,
                      input bit [3:0] be_i, input bit [3:0] a_i, input string tag);
    logic nv;
    logic [DW-1:0] nd, wnew, d;
    logic [3:0] eff;
    logic [1:0] lo;
    @(negedge clk);
    clk_en = ce; sel_a_n = sel[2]; sel_b = sel[1]; sel_c_n = sel[0];
    wr = wr_i; adv = adv_i; lane_we = be_i; addr = a_i; wdata = wp1;
    nv = 1'b0; nd = '0; wnew = '0;
    if (ce) begin
      if (sleep) b_act = 1'b0;
      else if (!adv_i) begin
        b_base = a_i; b_cnt = 2'd0; b_act = !sel[2] && sel[1] && !sel[0]; b_wr = wr_i;
      end else if (b_act) b_cnt = b_cnt + 2'd1;
      if (b_act) begin
        lo  = burst_lin ? 2'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
        eff = {b_base[3:2], lo};
        if (b_wr) begin
          d = DW'({$urandom(), $urandom()});
          for (int l = 0; l < LN; l++)
            if (be_i[l]) model[eff][l*LW +: LW] = d[l*LW +: LW];
          wnew = d;
        end else begin
          nv = 1'b1; nd = model[eff];
        end
      end
    end
    @(posedge clk);
    #1;
    if (ce) begin
      shown_v = cur_v; shown_d = cur_d; cur_v = nv; cur_d = nd;
      wp1 = wp0; wp0 = wnew;
    end
    look(tag);
  endtask

  localparam bit [2:0] ON  = 3'b010;
  localparam bit [2:0] OFF = 3'b110;

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    wr = 1'b0; adv = 1'b0; lane_we = '0; addr = '0; wdata = '0;
    burst_lin = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    wp0 = '0; wp1 = '0; cur_d = '0; shown_d = '0; cur_v = 1'b0; shown_v = 1'b0;
    b_base = '0; b_cnt = '0; b_act = 1'b0; b_wr = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 look("R1");
    @(negedge clk) rst_n = 1'b1;
    step(1, OFF, 0, 0, 4'hF, 0, "R1");

    for (int i = 0; i < 16; i++) step(1, ON, 1, 0, 4'hF, 4'(i), "R3");
    for (int i = 0; i < 16; i++) step(1, ON, 0, 0, 4'hF, 4'(i), "R2");
    for (int i = 0; i < 48; i++) step(1, ON, i[0], 0, 4'hF, 4'((i * 5) >> 1), "R3");

    for (int lin = 0; lin < 2; lin++) begin
      step(1, OFF, 0, 0, 4'hF, 0, "R6");
      burst_lin = lin[0];
      for (int s = 0; s < 16; s++) begin
        step(1, ON, 1, 0, 4'hF, 4'(s), "R6");
        for (int k = 0; k < 4; k++) step(1, 3'($urandom()), 1'($urandom()), 1, 4'hF, 4'($urandom()), "R7");
        step(1, ON, 0, 0, 4'hF, 4'(s), "R6");
        for (int k = 0; k < 4; k++) step(1, 3'($urandom()), 1'($urandom()), 1, 4'hF, 4'($urandom()), "R7");
      end
      for (int i = 0; i < 16; i++) step(1, ON, 0, 0, 4'hF, 4'(i), "R6");
    end

    for (int b = 0; b < 16; b++) begin
      step(1, ON, 1, 0, 4'(b), 4'd2, "R4");
      step(1, ON, 0, 0, 4'hF, 4'd2, "R4");
    end
    repeat (600) step(1, ($urandom() % 8 == 0) ? 3'($urandom()) : ON, 1'($urandom()),
                      ($urandom() % 4 == 0), 4'($urandom()), 4'($urandom() % 4), "R5");
    repeat (400) step(($urandom() % 3 != 0), ON, 1'($urandom()),
                      ($urandom() % 4 == 0), 4'($urandom()), 4'($urandom() % 4), "R9");

    for (int k = 0; k < 3; k++) begin
      step(1, ON ^ 3'(1 << k), 1, 0, 4'hF, 4'(k + 8), "R8");
      step(1, ON ^ 3'(1 << k), 0, 0, 4'hF, 4'(k + 8), "R8");
      step(1, ON, 0, 1, 4'hF, 4'(k + 8), "R8");
      step(1, ON, 0, 0, 4'hF, 4'(k + 8), "R8");
      step(1, OFF, 0, 0, 4'hF, 0, "R8");
    end

    for (int i = 0; i < 8; i++) begin
      step(1, ON, 0, 0, 4'hF, 4'(i), "R10");
      oe_n = 1'b1; #1 look("R10");
      oe_n = 1'b0; #1 look("R10");
    end
    oe_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1, ON, 0, 0, 4'hF, 4'(i), "R10");
    oe_n = 1'b0; #1 look("R10");

    step(1, ON, 1, 0, 4'hF, 4'd5, "R11");
    step(1, ON, 0, 0, 4'hF, 4'd6, "R11");
    sleep = 1'b1; #1 look("R11");
    for (int i = 0; i < 8; i++) step(1, ON, 1, i[0], 4'hF, 4'(i), "R11");
    sleep = 1'b0; #1 look("R11");
    for (int i = 0; i < 16; i++) step(1, ON, 0, 0, 4'hF, 4'(i), "R11");
    step(1, OFF, 0, 0, 4'hF, 0, "R11");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule